// File: doc/BRIEF.md
# Prefix-Extended Stack Store Unit

This block executes one kind of instruction: a 16-bit store that writes a source register to memory at the stack pointer plus a displacement. The instruction word holds only a 7-bit displacement. Up to two prefix words placed directly before it widen that displacement to 20 or 24 bits. The block keeps track of pending prefix words. It forms the effective address modulo 2^24. It then issues one 32-bit memory write whose upper byte is zero and whose lower 24 bits are the register value.

If the effective address is not word aligned, the block raises a one-cycle misalignment interrupt pulse. It still performs the write, at the address with its low two bits cleared. When the store sits in a branch delay slot, pending prefixes are discarded and only the 7-bit field is used. Every accepted word that is not a prefix also clears the prefix state. Words that are neither a prefix nor the store have no other effect.

The upstream pipeline offers words with `ins_valid` and sees `ins_ready`. The register file is read combinationally through `rf_raddr`/`rf_rdata`. The memory side uses a valid/ready pair.

Top module: `stk_store_unit`

## Requirements
- R1: A word whose bits 15:10 are all ones is the store. Bits 9:7 select the source register r0 to r7 and are driven on `rf_raddr` while the word is offered. Bits 6:0 are the low displacement field.
- R2: A store with no pending prefix writes to `sp` plus the zero-extended 7-bit field, modulo 2^24.
- R3: A prefix word has bits 15:13 equal to 3'b110, and bits 12:0 are its payload. With one pending prefix, the displacement is {payload, field[6:0]}, zero-extended to 24 bits. For example, payload 0x1 with field 0x4 gives an offset of 0x84.
- R4: With two pending prefixes, the displacement is {first payload bits 3:0, second payload bits 12:0, field[6:0]}.
- R5: The write data is 32 bits: bits 23:0 hold the selected register value and bits 31:24 are zero.
- R6: When the low two bits of the effective address are nonzero, `misalign_irq` is high for exactly the cycle in which the write is accepted. The write address always has its low two bits cleared.
- R7: A store offered with `ins_dslot` high uses only the 7-bit field, whatever prefixes are pending.
- R8: Every accepted word that is not a prefix clears the pending prefixes. A word that is neither a prefix nor the store starts no write.
- R9: The write request rises in the cycle after the store is accepted. `done` is high in the cycle the write is accepted. `busy` is high and `ins_ready` is low from the request until that acceptance.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R11: When a third consecutive prefix arrives, the oldest pending prefix is dropped and the latest two are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction word offered |
| ins_word | input | 16 | Instruction word |
| ins_dslot | input | 1 | Offered word sits in a branch delay slot |
| ins_ready | output | 1 | Block can accept a word |
| sp | input | 24 | Stack pointer value |
| rf_raddr | output | 3 | Source register index for the register file |
| rf_rdata | input | 24 | Register file read data |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 24 | Word-aligned write address |
| wr_data | output | 32 | Write data |
| misalign_irq | output | 1 | Misaligned address interrupt pulse |
| busy | output | 1 | Store in progress |
| done | output | 1 | Store completes this cycle |

## Verification
The in-RTL assertions check the cycle-level rules on every cycle:
- the write request follows an accepted store;
- `ins_ready` is low while busy;
- a stalled request holds its address and data;
- the pending prefix count is bounded and empties after any non-prefix word.

Only the bench scenarios can show that the address arithmetic is correct for zero, one, two and three prefixes. The same holds for delay-slot suppression, the zero upper data byte, and the interrupt pulse on misaligned sums. The bench compares these against an independent model under random prefix sequences, stack pointers, register values and memory stalls.

// File: rtl/stk_store_pkg.sv
package stk_store_pkg;
   localparam int INSN_W     = 16;
   localparam int OPC_W      = 6;
   localparam int REG_IDX_W  = 3;
   localparam int PFX_TAG_W  = 3;
   localparam int IMM_W      = INSN_W - OPC_W - REG_IDX_W;
   localparam int EXT_W      = INSN_W - PFX_TAG_W;

   localparam logic [OPC_W-1:0]     STORE_OPC = '1;
   localparam logic [PFX_TAG_W-1:0] PFX_TAG   = 3'b110;

   typedef enum logic {ST_IDLE, ST_WRITE} stk_state_e;

   function automatic logic is_store_word(input logic [INSN_W-1:0] w);
      return w[INSN_W-1 -: OPC_W] == STORE_OPC;
   endfunction

   function automatic logic is_prefix_word(input logic [INSN_W-1:0] w);
      return w[INSN_W-1 -: PFX_TAG_W] == PFX_TAG;
   endfunction
endpackage

// File: rtl/stk_prefix_track.sv
module stk_prefix_track
   import stk_store_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              consume,
   input  logic [INSN_W-1:0] word,
   output logic [1:0]        pfx_cnt,
   output logic [EXT_W-1:0]  pfx_first,
   output logic [EXT_W-1:0]  pfx_second
);
   logic is_pfx;
   assign is_pfx = is_prefix_word(word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfx_cnt    <= '0;
         pfx_first  <= '0;
         pfx_second <= '0;
      end else if (consume) begin
         if (!is_pfx) begin
            pfx_cnt <= '0;
         end else begin
            case (pfx_cnt)
               2'd0: begin
                  pfx_first <= word[EXT_W-1:0];
                  pfx_cnt   <= 2'd1;
               end
               2'd1: begin
                  pfx_second <= word[EXT_W-1:0];
                  pfx_cnt    <= 2'd2;
               end
               default: begin
                  pfx_first  <= pfx_second;
                  pfx_second <= word[EXT_W-1:0];
                  pfx_cnt    <= 2'd2;
               end
            endcase
         end
      end
   end

   // R11: never more than two prefixes held
   assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_cnt != 2'd3);
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
   import stk_store_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int HI_W       = 4,
   parameter int ALIGN_LOG2 = 2
) (
   input  logic [ADDR_W-1:0] sp,
   input  logic [IMM_W-1:0]  imm,
   input  logic [1:0]        pfx_cnt,
   input  logic [EXT_W-1:0]  pfx_first,
   input  logic [EXT_W-1:0]  pfx_second,
   input  logic              dslot,
   output logic [ADDR_W-1:0] aligned_addr,
   output logic              misaligned
);
   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      disp = '0;
      if (dslot || pfx_cnt == 2'd0) begin
         disp[IMM_W-1:0] = imm;
      end else if (pfx_cnt == 2'd1) begin
         disp[IMM_W+EXT_W-1:0] = {pfx_first, imm};
      end else begin
         disp = {pfx_first[HI_W-1:0], pfx_second, imm};
      end
   end

   assign sum = sp + disp;

   generate
      if (ALIGN_LOG2 == 0) begin : g_no_align
         assign aligned_addr = sum;
         assign misaligned   = 1'b0;
      end else begin : g_align
         assign aligned_addr = {sum[ADDR_W-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
         assign misaligned   = |sum[ALIGN_LOG2-1:0];
      end
   endgenerate
endmodule

// File: rtl/stk_store_unit.sv
module stk_store_unit
   import stk_store_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int REG_W      = 24,
   parameter int DATA_W     = 32,
   parameter int HI_W       = 4,
   parameter int ALIGN_LOG2 = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ins_valid,
   input  logic [INSN_W-1:0]    ins_word,
   input  logic                 ins_dslot,
   output logic                 ins_ready,
   input  logic [ADDR_W-1:0]    sp,
   output logic [REG_IDX_W-1:0] rf_raddr,
   input  logic [REG_W-1:0]     rf_rdata,
   output logic                 wr_valid,
   input  logic                 wr_ready,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 misalign_irq,
   output logic                 busy,
   output logic                 done
);
   localparam int PAD_W = DATA_W - REG_W;

   generate
      if (IMM_W + EXT_W + HI_W != ADDR_W) begin : g_bad_width
         $error("displacement pieces must add up to ADDR_W");
      end
      if (HI_W > EXT_W || HI_W < 1) begin : g_bad_hi
         $error("HI_W out of range");
      end
      if (REG_W > DATA_W) begin : g_bad_data
         $error("REG_W exceeds DATA_W");
      end
      if (ALIGN_LOG2 >= ADDR_W) begin : g_bad_align
         $error("ALIGN_LOG2 too large");
      end
   endgenerate

   stk_state_e          state_q;
   logic                fire, fire_store, is_pfx;
   logic [1:0]          pfx_cnt;
   logic [EXT_W-1:0]    pfx_first, pfx_second;
   logic [ADDR_W-1:0]   calc_addr;
   logic                calc_mis;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [DATA_W-1:0]   data_ext;
   logic                mis_q;

   assign ins_ready  = (state_q == ST_IDLE);
   assign fire       = ins_valid && ins_ready;
   assign fire_store = fire && is_store_word(ins_word);
   assign is_pfx     = is_prefix_word(ins_word);
   assign rf_raddr   = ins_word[INSN_W-OPC_W-1 -: REG_IDX_W];

   stk_prefix_track u_pfx (
      .clk        (clk),
      .rst_n      (rst_n),
      .consume    (fire),
      .word       (ins_word),
      .pfx_cnt    (pfx_cnt),
      .pfx_first  (pfx_first),
      .pfx_second (pfx_second)
   );

   stk_addr_gen #(
      .ADDR_W     (ADDR_W),
      .HI_W       (HI_W),
      .ALIGN_LOG2 (ALIGN_LOG2)
   ) u_agen (
      .sp           (sp),
      .imm          (ins_word[IMM_W-1:0]),
      .pfx_cnt      (pfx_cnt),
      .pfx_first    (pfx_first),
      .pfx_second   (pfx_second),
      .dslot        (ins_dslot),
      .aligned_addr (calc_addr),
      .misaligned   (calc_mis)
   );

   generate
      if (PAD_W == 0) begin : g_data_full
         assign data_ext = rf_rdata;
      end else begin : g_data_pad
         assign data_ext = {{PAD_W{1'b0}}, rf_rdata};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         mis_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (fire_store) begin
               state_q <= ST_WRITE;
               addr_q  <= calc_addr;
               data_q  <= data_ext;
               mis_q   <= calc_mis;
            end
            default: if (wr_ready) state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_valid     = (state_q == ST_WRITE);
   assign busy         = wr_valid;
   assign wr_addr      = addr_q;
   assign wr_data      = data_q;
   assign done         = wr_valid && wr_ready;
   assign misalign_irq = done && mis_q;

   // R9: accepted store raises a write request next cycle
   assert_req_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire_store |=> wr_valid);
   // R9: no word accepted while a store is in progress
   assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ins_ready);
   // R10: stalled request holds its contents
   assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
   // R8: any consumed non-prefix word empties the prefix state
   assert_pfx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !is_pfx) |=> (pfx_cnt == 2'd0));
endmodule

// File: tb/sim_stk_store_unit.sv
`timescale 1ns/1ps
module sim_stk_store_unit;
   localparam real HALF = 2.5;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        ins_valid = 0;
   logic [15:0] ins_word = '0;
   logic        ins_dslot = 0;
   logic        ins_ready;
   logic [23:0] sp = '0;
   logic [2:0]  rf_raddr;
   logic [23:0] rf_rdata;
   logic        wr_valid;
   logic        wr_ready = 0;
   logic [23:0] wr_addr;
   logic [31:0] wr_data;
   logic        misalign_irq, busy, done;

   logic [23:0] rf [8];
   assign rf_rdata = rf[rf_raddr];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // bench prefix model
   int          m_cnt = 0;
   logic [12:0] m_a = '0, m_b = '0;

   always #(HALF) clk = ~clk;

   stk_store_unit u0 (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .ins_dslot(ins_dslot), .ins_ready(ins_ready), .sp(sp), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .misalign_irq(misalign_irq),
      .busy(busy), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_sum(input logic [23:0] s, input logic [6:0] imm,
                                           input bit ds);
      logic [23:0] d;
      if (ds || m_cnt == 0) d = {17'd0, imm};
      else if (m_cnt == 1)  d = {4'd0, m_a, imm};
      else                  d = {m_a[3:0], m_b, imm};
      return s + d;
   endfunction

   task automatic put_word(input logic [15:0] w, input bit ds);
      @(negedge clk);
      chk("R9 ready before offer", ins_ready, 1);
      ins_valid = 1; ins_word = w; ins_dslot = ds;
      #1;
      chk("R1 rf_raddr", rf_raddr, w[9:7]);
      @(posedge clk);
      #1 ins_valid = 0; ins_dslot = 0;
   endtask

   task automatic send_prefix(input logic [12:0] p);
      put_word({3'b110, p}, 0);
      if (m_cnt == 0) begin m_a = p; m_cnt = 1; end
      else if (m_cnt == 1) begin m_b = p; m_cnt = 2; end
      else begin m_a = m_b; m_b = p; end
   endtask

   task automatic send_other(input logic [15:0] w);
      logic [15:0] x = w;
      if (x[15:13] == 3'b110 || x[15:13] == 3'b111) x[15:13] = 3'b010;
      put_word(x, $urandom_range(0, 1));
      m_cnt = 0;
      @(negedge clk);
      chk("R8 other opcode no write", wr_valid, 0);
      chk("R8 other opcode not busy", busy, 0);
   endtask

   task automatic send_store(input logic [2:0] rs, input logic [6:0] imm, input bit ds,
                             input logic [23:0] spv, input int stall);
      logic [23:0] s;
      logic [31:0] hold_d;
      logic [23:0] hold_a;
      s = exp_sum(spv, imm, ds);
      sp = spv;
      put_word({6'b111111, rs, imm}, ds);
      m_cnt = 0;
      @(negedge clk);
      chk("R9 wr_valid after accept", wr_valid, 1);
      chk("R9 busy", busy, 1);
      chk("R9 ins_ready low", ins_ready, 0);
      chk(ds ? "R7 dslot addr" : (s == spv + {17'd0, imm}) ? "R2 addr" : "R3/R4 addr",
          wr_addr, {s[23:2], 2'b00});
      chk("R6 aligned addr", wr_addr[1:0], 0);
      chk("R5 data", wr_data, {8'h00, rf[rs]});
      hold_a = wr_addr; hold_d = wr_data;
      for (int i = 0; i < stall; i++) begin
         chk("R9 no done while stalled", done, 0);
         chk("R6 no irq while stalled", misalign_irq, 0);
         @(negedge clk);
         chk("R10 hold valid", wr_valid, 1);
         chk("R10 hold addr", wr_addr, hold_a);
         chk("R10 hold data", wr_data, hold_d);
      end
      wr_ready = 1;
      #1;
      chk("R9 done", done, 1);
      chk("R6 irq pulse", misalign_irq, (s[1:0] != 0));
      @(negedge clk);
      wr_ready = $urandom_range(0, 1);
      #1;
      chk("R9 idle after done", busy, 0);
      chk("R6 irq single cycle", misalign_irq, 0);
      wr_ready = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 8; i++) rf[i] = $urandom;
      rf[3] = 24'hFFFFFF;
      repeat (4) @(posedge clk);
      #1;
      chk("R9 reset wr_valid", wr_valid, 0);
      chk("R9 reset busy", busy, 0);
      chk("R9 reset ready", ins_ready, 1);
      chk("R6 reset irq", misalign_irq, 0);
      rst_n = 1;

      // directed: R3 example, offset 0x84
      send_prefix(13'h1);
      send_store(3'd0, 7'h4, 0, 24'h100000, 0);
      // R2 no prefix, wrap modulo 2^24, full register R5
      send_store(3'd3, 7'h7F, 0, 24'hFFFFC0, 1);
      // R4 two prefixes, top of range
      send_prefix(13'h0AF);
      send_prefix(13'h1FFF);
      send_store(3'd1, 7'h10, 0, 24'h000400, 2);
      // R6 misaligned sum
      send_store(3'd2, 7'h03, 0, 24'h000100, 0);
      // R7 delay slot discards prefixes
      send_prefix(13'h123);
      send_store(3'd4, 7'h08, 1, 24'h200000, 0);
      // R8 other opcode clears a pending prefix
      send_prefix(13'h0FF);
      send_other(16'h1234);
      send_store(3'd5, 7'h0C, 0, 24'h300000, 0);
      // R11 third prefix drops the oldest
      send_prefix(13'h00F);
      send_prefix(13'h0A5);
      send_prefix(13'h1C3);
      send_store(3'd6, 7'h20, 0, 24'h010000, 1);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int np = $urandom_range(0, 3);
         for (int k = 0; k < np; k++) send_prefix($urandom);
         if ($urandom_range(0, 6) == 0) send_other($urandom);
         if ($urandom_range(0, 9) == 0) rf[$urandom_range(0, 7)] = $urandom;
         send_store($urandom, $urandom, ($urandom_range(0, 4) == 0),
                    ($urandom_range(0, 1) ? ($urandom & 24'hFFFFFC) : $urandom),
                    $urandom_range(0, 2));
      end

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(2.0 * HALF * 150000);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule